// File: doc/BRIEF.md
# Predicated Execution Condition Unit

This unit lets a small processor run the one or two instructions after a compare only when a chosen flag condition holds, without a branch. It watches the instruction word at the retire stage. When it sees one of three "if" forms, it tests the zero, carry and signed-less flags against a 3-bit condition code. It then loads a 2-bit predicate register. The low bit gates the next instruction and the high bit gates the one after it.

Every retired instruction moves the high bit down and refills the high bit with 1. A gated-off instruction is still fetched and retired, but it has no effect. It does not evaluate a new predicate, make a call or restore anything.

A call stores the high bit alongside the return address. The surrounding core pushes it out on `link_bit` and feeds it back on `ret_bit` when the subroutine returns. This way a false "else" bit still suppresses the instruction after the call site.

Top module: `cond_exec_unit`

## Requirements
- R1: After reset, `cond_state` is 2'b11 and `exec_en` is 1.
- R2: The condition code in instruction bits [2:0] tests: 0 z, 1 !z, 2 !c, 3 c, 4 !lt&!z, 5 lt&!z, 6 !lt|z, 7 lt|z. Here z is `flag_z`, c is `flag_c` and lt is `flag_lt`.
- R3: When the plain form (bits [15:3] = 13'b1010_0010_0000_0) is retired while enabled, `cond_state` becomes {1, test}.
- R4: When the double form (bits [15:3] = 13'b1010_0010_0000_1) is retired while enabled, `cond_state` becomes {test, test}.
- R5: When the either/or form (bits [15:3] = 13'b1010_0010_0001_0) is retired while enabled, `cond_state` becomes {!test, test}.
- R6: Any other enabled retire that is neither a call nor a return gives `cond_state` = {1, old bit 1}. Without `retire`, the state holds.
- R7: A retire while `exec_en` is 0 only shifts, giving {1, old bit 1}. This applies even if the word is an "if" form or `call_stb`/`ret_stb` is set.
- R8: An enabled retire with `call_stb` (and no "if" word) sets `cond_state` to 2'b11.
- R9: An enabled retire with `ret_stb` (no "if" word, no `call_stb`) sets `cond_state` to {1, `ret_bit`}.
- R10: `exec_en` equals bit 0 of `cond_state`, and `link_bit` equals bit 1. `link_bit` is the value to save with the return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word being retired |
| retire | input | 1 | One instruction retires this cycle |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_lt | input | 1 | Signed-less flag |
| call_stb | input | 1 | Retiring instruction is a call |
| ret_stb | input | 1 | Retiring instruction is a return |
| ret_bit | input | 1 | Predicate bit restored from the return record |
| exec_en | output | 1 | Current instruction takes effect |
| link_bit | output | 1 | Predicate bit to store with the return address |
| cond_state | output | 2 | Predicate register |

## Verification
Every state change appears one clock after the edge that samples a retire. `exec_en`, `link_bit` and `cond_state` all come straight from the register, so each result is due in the cycle right after its stimulus. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. It updates its own predicate model at the same point, so every comparison covers exactly one retire.

// File: rtl/cond_exec_unit.sv
module cond_exec_unit #(
  parameter int IW = 16,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr,
  input  logic          retire,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_lt,
  input  logic          call_stb,
  input  logic          ret_stb,
  input  logic          ret_bit,
  output logic          exec_en,
  output logic          link_bit,
  output logic [1:0]    cond_state
);
  localparam int OW = IW - CW;
  localparam logic [OW-1:0] OP_ONE  = OW'(13'b1010_0010_0000_0);
  localparam logic [OW-1:0] OP_BOTH = OW'(13'b1010_0010_0000_1);
  localparam logic [OW-1:0] OP_ALT  = OW'(13'b1010_0010_0001_0);

  logic [1:0]    cond_q, cond_d;
  logic          test;
  wire  [CW-1:0] code   = instr[CW-1:0];
  wire  [OW-1:0] opcode = instr[IW-1:CW];
  wire           is_one  = opcode == OP_ONE;
  wire           is_both = opcode == OP_BOTH;
  wire           is_alt  = opcode == OP_ALT;

  always_comb begin
    case (code[2:0])
      3'd0:    test = flag_z;
      3'd1:    test = !flag_z;
      3'd2:    test = !flag_c;
      3'd3:    test = flag_c;
      3'd4:    test = !flag_lt && !flag_z;
      3'd5:    test = flag_lt && !flag_z;
      3'd6:    test = !flag_lt || flag_z;
      default: test = flag_lt || flag_z;
    endcase
  end

  always_comb begin
    cond_d = {1'b1, cond_q[1]};
    if (!retire)        cond_d = cond_q;
    else if (!cond_q[0]) cond_d = {1'b1, cond_q[1]};
    else if (is_one)    cond_d = {1'b1, test};
    else if (is_both)   cond_d = {test, test};
    else if (is_alt)    cond_d = {!test, test};
    else if (call_stb)  cond_d = 2'b11;
    else if (ret_stb)   cond_d = {1'b1, ret_bit};
  end

  always_ff @(posedge clk)
    if (!rst_n) cond_q <= 2'b11;
    else        cond_q <= cond_d;

  assign exec_en    = cond_q[0];
  assign link_bit   = cond_q[1];
  assign cond_state = cond_q;
endmodule

// File: rtl/cond_exec_unit_chk.sv
module cond_exec_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] instr,
  input logic        retire,
  input logic        call_stb,
  input logic        ret_stb,
  input logic        ret_bit,
  input logic        exec_en,
  input logic [1:0]  cond_state
);
  wire w_one  = instr[15:3] == 13'b1010_0010_0000_0;
  wire w_both = instr[15:3] == 13'b1010_0010_0000_1;
  wire w_alt  = instr[15:3] == 13'b1010_0010_0001_0;
  wire w_if   = w_one || w_both || w_alt;
  wire go     = retire && exec_en;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(cond_state)); // R6
  AST_GATED_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !exec_en) |=> cond_state == {1'b1, $past(cond_state[1])}); // R7
  AST_ONE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (go && w_one) |=> cond_state[1]); // R3
  AST_BOTH_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (go && w_both) |=> cond_state[1] == cond_state[0]); // R4
  AST_ALT_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && w_alt) |=> cond_state[1] != cond_state[0]); // R5
  AST_CALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !w_if && call_stb) |=> cond_state == 2'b11); // R8
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !w_if && !call_stb && ret_stb) |=> cond_state == {1'b1, $past(ret_bit)}); // R9
endmodule

bind cond_exec_unit cond_exec_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .retire(retire),
  .call_stb(call_stb), .ret_stb(ret_stb), .ret_bit(ret_bit),
  .exec_en(exec_en), .cond_state(cond_state)
);

// File: tb/cond_exec_unit_test.sv
module cond_exec_unit_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] instr = 0;
  logic retire = 0, flag_z = 0, flag_c = 0, flag_lt = 0;
  logic call_stb = 0, ret_stb = 0, ret_bit = 0;
  logic exec_en, link_bit;
  logic [1:0] cond_state;
  logic [1:0] model;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cond_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .retire(retire),
    .flag_z(flag_z), .flag_c(flag_c), .flag_lt(flag_lt),
    .call_stb(call_stb), .ret_stb(ret_stb), .ret_bit(ret_bit),
    .exec_en(exec_en), .link_bit(link_bit), .cond_state(cond_state));

  function automatic logic eval(input logic [2:0] cc, input logic z, c, lt);
    case (cc)
      3'd0: return z;
      3'd1: return !z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return !lt && !z;
      3'd5: return lt && !z;
      3'd6: return !lt || z;
      default: return lt || z;
    endcase
  endfunction

  task automatic check(input logic [1:0] got, input logic [1:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: cond_state got %b expected %b", req, got, exp);
    end
    n_chk++;
    if (exec_en !== exp[0] || link_bit !== exp[1]) begin
      n_fail++;
      $display("FAIL R10 (%s): exec_en/link_bit got %b%b expected %b%b",
               req, exec_en, link_bit, exp[0], exp[1]);
    end
  endtask

  task automatic step(input logic [15:0] w, input logic rt, z, c, lt, cl, rs, rb);
    string req;
    logic t;
    @(negedge clk);
    instr = w; retire = rt; flag_z = z; flag_c = c; flag_lt = lt;
    call_stb = cl; ret_stb = rs; ret_bit = rb;
    t = eval(w[2:0], z, c, lt);
    @(posedge clk); #1;
    if (!rt)                                   begin req = "R6"; end
    else if (!model[0])                        begin req = "R7"; model = {1'b1, model[1]}; end
    else if (w[15:3] == 13'b1010_0010_0000_0)  begin req = "R3/R2"; model = {1'b1, t}; end
    else if (w[15:3] == 13'b1010_0010_0000_1)  begin req = "R4/R2"; model = {t, t}; end
    else if (w[15:3] == 13'b1010_0010_0001_0)  begin req = "R5/R2"; model = {!t, t}; end
    else if (cl)                               begin req = "R8"; model = 2'b11; end
    else if (rs)                               begin req = "R9"; model = {1'b1, rb}; end
    else                                       begin req = "R6"; model = {1'b1, model[1]}; end
    check(cond_state, model, req);
  endtask

  localparam logic [15:0] W_ONE = 16'hA200, W_BOTH = 16'hA208, W_ALT = 16'hA210;
  localparam logic [15:0] W_NOP = 16'h1234;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    model = 2'b11;
    #1; check(cond_state, 2'b11, "R1");
    // R2: every code on the plain form, flags swept
    for (int f = 0; f < 8; f++)
      for (int cc = 0; cc < 8; cc++) begin
        step(W_ONE | 16'(cc), 1, f[0], f[1], f[2], 0, 0, 0);
        step(W_NOP, 1, 0, 0, 0, 0, 0, 0);
        step(W_NOP, 1, 0, 0, 0, 0, 0, 0);
      end
    // R5 either/or: false test, then else branch executes
    step(W_ALT | 16'd0, 1, 0, 0, 0, 0, 0, 0);
    step(W_NOP, 1, 0, 0, 0, 0, 0, 0);
    step(W_NOP, 1, 0, 0, 0, 0, 0, 0);
    // R4 double false suppresses two; R7 gated "if" ignored
    step(W_BOTH | 16'd3, 1, 0, 0, 0, 0, 0, 0);
    step(W_ONE | 16'd0, 1, 1, 0, 0, 0, 0, 0);
    step(W_NOP, 1, 0, 0, 0, 1, 0, 0);
    step(W_NOP, 1, 0, 0, 0, 0, 0, 0);
    // R8/R9 call from the then slot with else bit 0, restored on return
    step(W_ALT | 16'd1, 1, 0, 0, 0, 0, 0, 0);
    step(W_NOP, 1, 0, 0, 0, 1, 0, 0);
    step(W_NOP, 1, 0, 0, 0, 0, 0, 0);
    step(W_NOP, 0, 0, 0, 0, 0, 0, 0);
    step(W_NOP, 1, 0, 0, 0, 0, 1, 0);
    step(W_NOP, 1, 0, 0, 0, 0, 0, 0);
    // R7 gated return does not restore
    step(W_BOTH | 16'd1, 1, 1, 0, 0, 0, 0, 0);
    step(W_NOP, 1, 0, 0, 0, 0, 1, 1);
    // near-miss encoding shifts only (R6)
    step(16'hA218, 1, 1, 1, 1, 0, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      int k = $urandom_range(0, 5);
      case (k)
        0: w = W_ONE  | 16'($urandom_range(0, 7));
        1: w = W_BOTH | 16'($urandom_range(0, 7));
        2: w = W_ALT  | 16'($urandom_range(0, 7));
        default: w = 16'($urandom);
      endcase
      step(w, ($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0), 1'($urandom));
    end
    // R1 again after mid-run reset
    @(negedge clk); rst_n = 0; retire = 0;
    @(posedge clk); #1; model = 2'b11;
    check(cond_state, 2'b11, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule